// File: doc/BRIEF.md
# Oversampling Accumulator with Rounded Averaging

This block turns a stream of 12-bit conversion results from one channel into oversampled words. It sums a programmable power-of-two number of consecutive samples, from 2 up to 256. It then divides the sum by a programmable power of two, from 1 to 256, rounding to nearest. The result leaves the block as a right-aligned 16-bit word together with a one-clock valid strobe.

A sequencer drives it with a sample and a sample strobe. The ratio and shift selects are taken at the first sample of each group, so software may change them at any time without damaging a group already in progress. A synchronous clear drops a partial group, for example when a conversion sequence is aborted.

Top module: `ovs_accum_top`

## Requirements
- R1: A ratio select value k (0 to 7) makes one group from 2^(k+1) accepted samples, so 0 gives 2 samples and 7 gives 256. Exactly one output is produced per completed group.
- R2: A shift select value s from 0 to 8 makes the output (sum + 2^(s-1)) >> s. When s is 0 the output is the plain sum, with no rounding term. Values above 8 act as 8.
- R3: The output word is the low 16 bits of the rounded, shifted sum, placed right-aligned in out_data[15:0]. A larger result wraps and does not saturate. For example, a 32-sample full-scale sum 0x1FFE0 with shift 0 gives 0xFFE0.
- R4: out_valid is high for exactly one clock, in the cycle after the group's last sample is accepted. Between strobes, out_data holds the last result.
- R5: While clear is high, the partial sum and the sample count are discarded and no sample is accepted. No output is ever produced for the discarded samples.
- R6: The ratio and shift selects are taken at the first accepted sample of a group and held for that group. Changing them mid-group has no effect on that group's length or result.
- R7: A sample strobe while enable is low is ignored, and any partial sum is kept.
- R8: After reset, out_valid is 0 and out_data is 0x0000.
- R9: Full-scale cases round correctly. A 4-sample sum of 0x3FFC gives 0x0800 with shift 3 and 0x0FFF with shift 2. A 256-sample sum 0xFFF00 with shift 8 gives 0x0FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Accept sample strobes when high |
| clear | input | 1 | Synchronous abort of the partial group |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Conversion result |
| ratio_sel | input | 3 | Group size select, 2^(k+1) samples |
| shift_sel | input | 4 | Right shift select, 0 to 8 |
| out_data | output | 16 | Right-aligned oversampled result |
| out_valid | output | 1 | One-clock result strobe |

## Verification
A wrong sample count shows up at the ports as a strobe that arrives too early or too late. The bench sees this within one group, at most 256 accepted samples. A corrupted partial sum or a wrong latched shift shows as a wrong out_data value at the next strobe. A clear that fails to flush the group shows as an extra or misplaced strobe, or as a wrong value in the following group. The bench predicts every cycle's out_valid and, on each strobe, the exact word, so these faults are caught at their first visible effect.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int SMP_W   = 12;
  localparam int SEL_W   = 3;
  localparam int SHF_W   = 4;
  localparam int MAX_SHF = 8;
  localparam int OUT_W   = 16;
  localparam int CNT_W   = SEL_W + 6;            // holds 2^(2^SEL_W) = 256
  localparam int ACC_W   = SMP_W + (1 << SEL_W); // 20 bits for 0xFFF * 256

  // Group size in samples for a ratio select value.
  function automatic logic [CNT_W-1:0] ratio_to_len(input logic [SEL_W-1:0] sel);
    return CNT_W'(2) << sel;
  endfunction

  // Shift amounts above the maximum behave as the maximum.
  function automatic logic [SHF_W-1:0] clamp_shift(input logic [SHF_W-1:0] s);
    return (s > SHF_W'(MAX_SHF)) ? SHF_W'(MAX_SHF) : s;
  endfunction

  // Round-to-nearest right shift, keeping the low OUT_W bits.
  function automatic logic [OUT_W-1:0] round_shift(input logic [ACC_W-1:0] sum,
                                                   input logic [SHF_W-1:0] sh);
    logic [ACC_W:0] ext;
    ext = {1'b0, sum};
    if (sh != '0) ext = ext + ((ACC_W+1)'(1) << (sh - SHF_W'(1)));
    ext = ext >> sh;
    return ext[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/ovs_cfg_hold.sv
module ovs_cfg_hold
  import ovs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_start,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic [SHF_W-1:0] shift_sel,
  output logic [CNT_W-1:0] cur_len,
  output logic [SHF_W-1:0] cur_shift
);
  logic [CNT_W-1:0] len_q;
  logic [SHF_W-1:0] shf_q;
  logic [CNT_W-1:0] len_in;
  logic [SHF_W-1:0] shf_in;

  assign len_in    = ratio_to_len(ratio_sel);
  assign shf_in    = clamp_shift(shift_sel);
  assign cur_len   = grp_start ? len_in : len_q;
  assign cur_shift = grp_start ? shf_in : shf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= CNT_W'(2);
      shf_q <= '0;
    end else if (grp_start) begin
      len_q <= len_in;
      shf_q <= shf_in;
    end
  end

  // R6: held settings move only at a group start
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_start |=> ($stable(len_q) && $stable(shf_q)));
  p_shift_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shf_q <= SHF_W'(MAX_SHF));
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             clear,
  input  logic [CNT_W-1:0] group_len,
  input  logic [SMP_W-1:0] sample,
  output logic [CNT_W-1:0] cnt_q,
  output logic [ACC_W-1:0] sum_next,
  output logic             grp_last
);
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign sum_next = acc_q + ACC_W'(sample);
  assign grp_last = take && (cnt_inc == group_len);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (grp_last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= sum_next;
        cnt_q <= cnt_inc;
      end
    end
  end

  // R1: the count stays below the group length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < group_len);
  // R3: the sum never exceeds full scale for the samples taken
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC_W+CNT_W)'(acc_q) <= (ACC_W+CNT_W)'(cnt_q) * (ACC_W+CNT_W)'((1 << SMP_W) - 1));
  // R5: clear flushes the partial group
  p_clear_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && acc_q == '0));
  // R7: nothing moves without an accepted sample
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> ($stable(acc_q) && $stable(cnt_q)));
endmodule

// File: rtl/ovs_out_stage.sv
module ovs_out_stage
  import ovs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_last,
  input  logic [ACC_W-1:0] sum_next,
  input  logic [SHF_W-1:0] cur_shift,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= grp_last;
      if (grp_last) out_data <= round_shift(sum_next, cur_shift);
    end
  end

  // R4: strobe is a single clock
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R4: data held between strobes
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_last |=> $stable(out_data));
endmodule

// File: rtl/ovs_accum_top.sv
module ovs_accum_top
  import ovs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             smp_valid,
  input  logic [11:0]      smp_data,
  input  logic [2:0]       ratio_sel,
  input  logic [3:0]       shift_sel,
  output logic [15:0]      out_data,
  output logic             out_valid
);
  logic             take;
  logic             grp_start;
  logic             grp_last;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_len;
  logic [SHF_W-1:0] cur_shift;
  logic [ACC_W-1:0] sum_next;

  assign take      = enable && smp_valid && !clear;
  assign grp_start = take && (cnt_q == '0);

  ovs_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .grp_start(grp_start),
    .ratio_sel(ratio_sel), .shift_sel(shift_sel),
    .cur_len(cur_len), .cur_shift(cur_shift)
  );

  ovs_accum u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .clear(clear),
    .group_len(cur_len), .sample(smp_data),
    .cnt_q(cnt_q), .sum_next(sum_next), .grp_last(grp_last)
  );

  ovs_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .grp_last(grp_last), .sum_next(sum_next),
    .cur_shift(cur_shift), .out_data(out_data), .out_valid(out_valid)
  );

  // R5: a clear cycle never completes a group
  p_clear_no_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !out_valid);
  // R7: an ignored strobe produces no output
  p_disabled_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_valid);
  // R1: a strobe follows only an accepted sample
  p_valid_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !out_valid);
endmodule

// File: tb/ovs_accum_tb_top.sv
module ovs_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        clear = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [2:0]  ratio_sel = '0;
  logic [3:0]  shift_sel = '0;
  logic [15:0] out_data;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model state
  int          m_cnt = 0;
  int          m_len = 2;
  int          m_shf = 0;
  longint      m_sum = 0;
  logic        e_valid = 1'b0;
  logic [15:0] e_data = '0;

  always #10 clk = ~clk;

  ovs_accum_top dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .smp_valid(smp_valid), .smp_data(smp_data), .ratio_sel(ratio_sel),
    .shift_sel(shift_sel), .out_data(out_data), .out_valid(out_valid)
  );

  // nearest-integer division by 2^s, written as floor((2*sum + 2^s) / 2^(s+1))
  function automatic logic [15:0] ref_avg(longint sum, int s);
    longint q;
    if (s == 0) q = sum;
    else q = (2 * sum + (longint'(1) << s)) / (longint'(1) << (s + 1));
    return q[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // one clock: drive, update model, sample 2 ns after the edge
  task automatic step(logic v, logic [11:0] d, logic clr, logic en, string req);
    smp_valid = v; smp_data = d; clear = clr; enable = en;
    e_valid = 1'b0;
    if (clr) begin
      m_cnt = 0; m_sum = 0;
    end else if (v && en) begin
      if (m_cnt == 0) begin
        m_len = 2 << ratio_sel;
        m_shf = (shift_sel > 8) ? 8 : int'(shift_sel);
      end
      m_sum += d;
      m_cnt++;
      if (m_cnt == m_len) begin
        e_valid = 1'b1;
        e_data = ref_avg(m_sum, m_shf);
        m_cnt = 0; m_sum = 0;
      end
    end
    @(posedge clk);
    #2;
    check({req, " valid"}, 16'(out_valid), 16'(e_valid));
    check({req, " data"}, out_data, e_data);
  endtask

  task automatic group(int k, int s, logic [11:0] d, string req);
    ratio_sel = 3'(k); shift_sel = 4'(s);
    for (int i = 0; i < (2 << k); i++) step(1'b1, d, 1'b0, 1'b1, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset valid", 16'(out_valid), 16'h0);
    check("R8 reset data", out_data, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R9 full-scale rounding corners
    group(1, 3, 12'hFFF, "R9 4x s3");
    check("R9 4x s3 value", out_data, 16'h0800);
    group(1, 2, 12'hFFF, "R9 4x s2");
    check("R9 4x s2 value", out_data, 16'h0FFF);
    group(7, 8, 12'hFFF, "R9 256x s8");
    check("R9 256x s8 value", out_data, 16'h0FFF);
    // R3 wrap to low 16 bits
    group(4, 0, 12'hFFF, "R3 32x s0");
    check("R3 wrap value", out_data, 16'hFFE0);
    group(7, 0, 12'hFFF, "R3 256x s0");
    check("R3 wrap 256x value", out_data, 16'hFF00);
    // R2 clamp of shift above 8
    group(7, 15, 12'hFFF, "R2 clamp");
    check("R2 clamp value", out_data, 16'h0FFF);
    // R2 odd value, no rounding at shift 0
    group(0, 0, 12'h001, "R2 s0");
    check("R2 s0 value", out_data, 16'h0002);
    group(0, 1, 12'h001, "R2 s1");
    step(1'b0, 12'h0, 1'b0, 1'b1, "R4 hold");
    check("R4 hold value", out_data, 16'h0001);

    // R5 clear drops the partial group
    ratio_sel = 3'd1; shift_sel = 4'd0;
    step(1'b1, 12'h100, 1'b0, 1'b1, "R5 part");
    step(1'b1, 12'h100, 1'b0, 1'b1, "R5 part");
    step(1'b1, 12'h100, 1'b1, 1'b1, "R5 clear");
    group(1, 0, 12'h003, "R5 after clear");
    check("R5 fresh group value", out_data, 16'h000C);

    // R6 mid-group change of selects
    ratio_sel = 3'd1; shift_sel = 4'd1;
    step(1'b1, 12'h011, 1'b0, 1'b1, "R6 start");
    ratio_sel = 3'd0; shift_sel = 4'd0;
    step(1'b1, 12'h011, 1'b0, 1'b1, "R6 mid");
    ratio_sel = 3'd5; shift_sel = 4'd7;
    step(1'b1, 12'h011, 1'b0, 1'b1, "R6 mid");
    step(1'b1, 12'h011, 1'b0, 1'b1, "R6 end");
    check("R6 value", out_data, 16'h0022);

    // R7 disabled strobes ignored, partial kept
    ratio_sel = 3'd0; shift_sel = 4'd0;
    step(1'b1, 12'h005, 1'b0, 1'b1, "R7 first");
    step(1'b1, 12'hFFF, 1'b0, 1'b0, "R7 ignored");
    step(1'b1, 12'hFFF, 1'b0, 1'b0, "R7 ignored");
    step(1'b1, 12'h006, 1'b0, 1'b1, "R7 second");
    check("R7 value", out_data, 16'h000B);

    // R1 R4 R5 R6 R7 constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic v, c, e;
      ratio_sel = 3'($urandom % 4);
      shift_sel = 4'($urandom % 11);
      v = ($urandom % 10) < 8;
      c = ($urandom % 40) == 0;
      e = ($urandom % 10) != 0;
      step(v, 12'($urandom), c, e, "R1 random");
    end
    for (int i = 0; i < 2000; i++) begin
      ratio_sel = 3'($urandom % 8);
      shift_sel = 4'($urandom % 9);
      step(1'b1, (($urandom % 2) == 0) ? 12'hFFF : 12'($urandom), 1'b0, 1'b1, "R3 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule